// File: doc/BRIEF.md
# Quad-Data-Rate Burst SRAM Port Model

This block is a synthesizable behavioural model of a burst SRAM with one port for reads and a separate port for writes. Both ports run at the same time. A controller under test drives active-low port selects and addresses once per memory cycle. It then streams write words in, or collects read words, on both halves of that cycle. The storage is small, 256 words of 18 bits by default, so the model fits in a simulation or an emulation fixture next to the controller it exercises.

One memory cycle is two edges of the double-rate input clock `clk2x`. The output `k_phase` tells which half comes next. When it is low, the next `clk2x` edge is the main (K) rise. When it is high, the next edge is the complementary (K#) rise. Each access moves four words within an aligned group of four locations.

The protocol has no flow control. A burst cannot be stalled, so there is no ready signal, and a controller must meet the fixed beat timing. Word 0 of a group is at address bits [1:0] = 00. Byte lane b covers data bits [9b+8:9b].

Top module: `qdr_burst_sram`

## Requirements
- R1: During reset and directly after it, `rd_valid` is low, `rd_data` is zero and `k_phase` is low. `k_phase` then alternates on every `clk2x` edge, and the first edge after reset is a K rise.
- R2: The port selects are active low and are sampled only at K rises. A select that is low only at a K# edge starts nothing.
- R3: A write accepted at K rise edge E captures word k of its group from `wr_data` at edge E+2+k, for k = 0..3.
- R4: `wr_be_n` is sampled with each write word. Bit b low writes byte lane b (bits [9b+8:9b]). Bit b high leaves that lane of that word unchanged.
- R5: A read accepted at edge E drives word k on `rd_data` after edge E+5+k. `rd_valid` is high for exactly those four half-cycles. `rd_data` is zero whenever `rd_valid` is low.
- R6: Bursts always cover the aligned group `{addr[7:2], k}` in order k = 0..3. Address bits [1:0] are ignored on both ports.
- R7: A read and a write accepted at the same K rise are both carried out.
- R8: Each read word holds the contents at the read's accepting edge. A write word captured at or after that edge is not visible to it.
- R9: A read select at the K rise right after an accepted read is ignored. A read accepted two cycles after another continues `rd_valid` with no gap.
- R10: A write select at the K rise right after an accepted write is ignored, and the stream data that follows is not stored. Writes two cycles apart are both stored.
- R11: With both selects high, the ports stay idle. `wr_data` and `wr_be_n` activity changes no location and no read output appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Double-rate clock; each rising edge is one half memory cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_sel_n | input | 1 | Read port select, active low, sampled at K rises |
| rd_addr | input | 8 | Read address; bits [1:0] ignored |
| wr_sel_n | input | 1 | Write port select, active low, sampled at K rises |
| wr_addr | input | 8 | Write address; bits [1:0] ignored |
| wr_data | input | 18 | Write word, sampled at each write beat edge |
| wr_be_n | input | 2 | Active-low byte lane write enables, one per 9-bit lane |
| k_phase | output | 1 | Low when the next clk2x edge is a K rise |
| rd_valid | output | 1 | High while a read word is on rd_data |
| rd_data | output | 18 | Read word |

## Verification
A read acceptance and a write acceptance can fall on the same K rise, and so can a read snapshot and an in-flight write word. The bench provokes both by asserting the two selects together: once to different groups, once to the same group. It judges the result by reading back with the written data as the reference. A read of the same group must return the older contents. A later read must show the new ones. A second overlap arises when the next acceptance lands while a burst is still streaming. Selects issued one cycle after an accepted burst must leave no trace on `rd_valid` or on memory. Selects issued two cycles after must stream seamlessly.

// File: rtl/qdr_pkg.sv
package qdr_pkg;
  // Words moved by one access and the width of the index within a group.
  localparam int unsigned BURST  = 4;
  localparam int unsigned BIDX_W = 2;
  // Pipe slot (counted in half cycles after acceptance, pre-edge view)
  // that carries the first beat of each port.
  localparam int unsigned WR_FIRST = 1;
  localparam int unsigned RD_FIRST = 4;
endpackage

// File: rtl/qdr_burst_pipe.sv
module qdr_burst_pipe
  import qdr_pkg::*;
#(
  parameter int unsigned GW    = 6,
  parameter int unsigned FIRST = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              k_edge,
  input  logic              sel_n,
  input  logic [GW-1:0]     grp_in,
  input  logic              tag_in,
  output logic              acc,
  output logic              beat_v,
  output logic [BIDX_W-1:0] beat_idx,
  output logic [GW-1:0]     beat_grp,
  output logic              beat_tag
);
  localparam int unsigned DEPTH = FIRST + BURST;

  logic [DEPTH-1:0] vld_q;
  logic [DEPTH-1:0] tag_q;
  logic [GW-1:0]    grp_q [DEPTH];

  // slot 1 valid at a K rise means a command was taken one cycle ago
  assign acc = k_edge & ~sel_n & ~vld_q[1];

  always_ff @(posedge clk) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= {vld_q[DEPTH-2:0], acc};
  end

  always_ff @(posedge clk) begin
    tag_q    <= {tag_q[DEPTH-2:0], tag_in};
    grp_q[0] <= grp_in;
  end

  for (genvar s = 1; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk) grp_q[s] <= grp_q[s-1];
  end

  // accepts are at least four slots apart, so at most one window slot is set
  always_comb begin
    beat_v   = 1'b0;
    beat_idx = '0;
    beat_grp = '0;
    beat_tag = 1'b0;
    for (int j = 0; j < BURST; j++) begin
      if (vld_q[FIRST+j]) begin
        beat_v   = 1'b1;
        beat_idx = BIDX_W'(j);
        beat_grp = grp_q[FIRST+j];
        beat_tag = tag_q[FIRST+j];
      end
    end
  end
endmodule

// File: rtl/qdr_array.sv
module qdr_array
  import qdr_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 18,
  parameter int unsigned BW = 9,
  localparam int unsigned NB = DW / BW,
  localparam int unsigned GW = AW - BIDX_W
) (
  input  logic                clk,
  input  logic                we,
  input  logic [AW-1:0]       waddr,
  input  logic [DW-1:0]       wdata,
  input  logic [NB-1:0]       wbe_n,
  input  logic [GW-1:0]       rgrp,
  output logic [BURST*DW-1:0] rgroup
);
  localparam int unsigned WORDS = 1 << AW;

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int b = 0; b < NB; b++) begin
        if (!wbe_n[b]) mem[waddr][b*BW +: BW] <= wdata[b*BW +: BW];
      end
    end
  end

  // whole aligned group read at once, pre-edge contents
  always_comb begin
    for (int k = 0; k < BURST; k++) begin
      rgroup[k*DW +: DW] = mem[{rgrp, BIDX_W'(k)}];
    end
  end
endmodule

// File: rtl/qdr_burst_sram.sv
module qdr_burst_sram
  import qdr_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 18,
  parameter int unsigned BW = 9,
  localparam int unsigned NB = DW / BW
) (
  input  logic          clk2x,
  input  logic          rst_n,
  input  logic          rd_sel_n,
  input  logic [AW-1:0] rd_addr,
  input  logic          wr_sel_n,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [NB-1:0] wr_be_n,
  output logic          k_phase,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  localparam int unsigned GW = AW - BIDX_W;

  logic ph_q;
  logic k_edge;

  always_ff @(posedge clk2x) begin
    if (!rst_n) ph_q <= 1'b0;
    else        ph_q <= ~ph_q;
  end
  assign k_phase = ph_q;
  assign k_edge  = ~ph_q;

  logic unused_addr_lo;
  assign unused_addr_lo = ^{rd_addr[BIDX_W-1:0], wr_addr[BIDX_W-1:0]};

  // write port
  logic              wr_acc;
  logic              wbeat_v;
  logic [BIDX_W-1:0] wbeat_idx;
  logic [GW-1:0]     wbeat_grp;
  logic              unused_wtag;

  qdr_burst_pipe #(.GW(GW), .FIRST(WR_FIRST)) u_wpipe (
    .clk(clk2x), .rst_n(rst_n), .k_edge(k_edge), .sel_n(wr_sel_n),
    .grp_in(wr_addr[AW-1:BIDX_W]), .tag_in(1'b0),
    .acc(wr_acc), .beat_v(wbeat_v), .beat_idx(wbeat_idx),
    .beat_grp(wbeat_grp), .beat_tag(unused_wtag)
  );

  // read port
  logic              rd_acc;
  logic              rbeat_v;
  logic [BIDX_W-1:0] rbeat_idx;
  logic [GW-1:0]     unused_rgrp;
  logic              rbeat_tag;
  logic              rbank_q;

  qdr_burst_pipe #(.GW(GW), .FIRST(RD_FIRST)) u_rpipe (
    .clk(clk2x), .rst_n(rst_n), .k_edge(k_edge), .sel_n(rd_sel_n),
    .grp_in(rd_addr[AW-1:BIDX_W]), .tag_in(rbank_q),
    .acc(rd_acc), .beat_v(rbeat_v), .beat_idx(rbeat_idx),
    .beat_grp(unused_rgrp), .beat_tag(rbeat_tag)
  );

  logic [BURST*DW-1:0] rgroup;

  qdr_array #(.AW(AW), .DW(DW), .BW(BW)) u_arr (
    .clk(clk2x), .we(wbeat_v), .waddr({wbeat_grp, wbeat_idx}),
    .wdata(wr_data), .wbe_n(wr_be_n),
    .rgrp(rd_addr[AW-1:BIDX_W]), .rgroup(rgroup)
  );

  // two snapshot banks: the next read may be taken while one still streams
  logic [BURST*DW-1:0] snap_q [2];

  always_ff @(posedge clk2x) begin
    if (!rst_n)      rbank_q <= 1'b0;
    else if (rd_acc) rbank_q <= ~rbank_q;
  end

  always_ff @(posedge clk2x) begin
    if (rd_acc) snap_q[rbank_q] <= rgroup;
  end

  always_ff @(posedge clk2x) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else if (rbeat_v) begin
      rd_valid <= 1'b1;
      rd_data  <= snap_q[rbeat_tag][rbeat_idx*DW +: DW];
    end else begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end
  end
endmodule

// File: rtl/qdr_burst_sram_chk.sv
module qdr_burst_sram_chk (
  input logic clk2x,
  input logic rst_n,
  input logic k_phase,
  input logic rd_valid,
  input logic rd_acc,
  input logic wr_acc
);
  // R5: the first read word lands on a K# edge, so K rise is next
  a_r5_rise_on_kbar: assert property (@(posedge clk2x) disable iff (!rst_n)
    $rose(rd_valid) |-> !k_phase);

  // R5: a valid window lasts four half cycles
  a_r5_four_beats: assert property (@(posedge clk2x) disable iff (!rst_n)
    $rose(rd_valid) |=> rd_valid ##1 rd_valid ##1 rd_valid);

  // R5: valid starts five edges after the accepting edge
  a_r5_latency: assert property (@(posedge clk2x) disable iff (!rst_n)
    $rose(rd_valid) |-> $past(rd_acc, 6));

  // R9: reads are taken at most once per two memory cycles
  a_r9_read_spacing: assert property (@(posedge clk2x) disable iff (!rst_n)
    rd_acc |=> !rd_acc ##1 !rd_acc ##1 !rd_acc);

  // R10: writes are taken at most once per two memory cycles
  a_r10_write_spacing: assert property (@(posedge clk2x) disable iff (!rst_n)
    wr_acc |=> !wr_acc ##1 !wr_acc ##1 !wr_acc);
endmodule

bind qdr_burst_sram qdr_burst_sram_chk chk_i (
  .clk2x(clk2x), .rst_n(rst_n), .k_phase(k_phase),
  .rd_valid(rd_valid), .rd_acc(rd_acc), .wr_acc(wr_acc)
);

// File: tb/qdr_burst_sram_tb_top.sv
module qdr_burst_sram_tb_top;
  typedef logic [4*18-1:0] grp_t;

  logic        clk2x = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_sel_n = 1'b1;
  logic [7:0]  rd_addr = '0;
  logic        wr_sel_n = 1'b1;
  logic [7:0]  wr_addr = '0;
  logic [17:0] wr_data = '0;
  logic [1:0]  wr_be_n = '1;
  logic        k_phase;
  logic        rd_valid;
  logic [17:0] rd_data;

  int checks = 0;
  int fails  = 0;

  always #4ns clk2x = ~clk2x;

  qdr_burst_sram dut_i (
    .clk2x(clk2x), .rst_n(rst_n), .rd_sel_n(rd_sel_n), .rd_addr(rd_addr),
    .wr_sel_n(wr_sel_n), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_be_n(wr_be_n), .k_phase(k_phase), .rd_valid(rd_valid),
    .rd_data(rd_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_grp(input string req, input grp_t act, input grp_t exp);
    for (int k = 0; k < 4; k++) chk(req, 32'(act[k*18 +: 18]), 32'(exp[k*18 +: 18]));
  endtask

  task automatic idle_inputs();
    rd_sel_n = 1'b1; wr_sel_n = 1'b1; wr_data = '0; wr_be_n = '1;
  endtask

  task automatic to_k_rise();
    @(negedge clk2x);
    while (k_phase) @(negedge clk2x);
  endtask

  // Command A at negedge 0, command B at negedge boff (both before K rises).
  task automatic run2(
    input bit rdA, input logic [7:0] raA, input bit wrA, input logic [7:0] waA,
    input grp_t wdA, input logic [7:0] beA,
    input bit rdB, input logic [7:0] raB, input bit wrB, input logic [7:0] waB,
    input grp_t wdB, input logic [7:0] beB, input int boff,
    output grp_t qa, output grp_t qb, output logic [15:0] vld);
    qa = '0; qb = '0; vld = '0;
    to_k_rise();
    for (int i = 0; i < 16; i++) begin
      if (i > 0) @(negedge clk2x);
      vld[i] = rd_valid;
      if (i >= 6 && i <= 9) qa[(i-6)*18 +: 18] = rd_data;
      if (i >= boff+6 && i <= boff+9) qb[(i-boff-6)*18 +: 18] = rd_data;
      idle_inputs();
      if (i == 0) begin
        rd_sel_n = ~rdA; rd_addr = raA; wr_sel_n = ~wrA; wr_addr = waA;
      end
      if (i == boff) begin
        rd_sel_n = ~rdB; rd_addr = raB; wr_sel_n = ~wrB; wr_addr = waB;
      end
      if (wrA && i >= 2 && i <= 5) begin
        wr_data = wdA[(i-2)*18 +: 18]; wr_be_n = beA[(i-2)*2 +: 2];
      end else if (wrB && i >= boff+2 && i <= boff+5) begin
        wr_data = wdB[(i-boff-2)*18 +: 18]; wr_be_n = beB[(i-boff-2)*2 +: 2];
      end
    end
    idle_inputs();
  endtask

  task automatic wr1(input logic [7:0] a, input grp_t d, input logic [7:0] be);
    grp_t qa, qb; logic [15:0] v;
    run2(0, 0, 1, a, d, be, 0, 0, 0, 0, '0, '1, 4, qa, qb, v);
  endtask

  task automatic rd1(input logic [7:0] a, output grp_t q, output logic [15:0] v);
    grp_t qb;
    run2(1, a, 0, 0, '0, '1, 0, 0, 0, 0, '0, '1, 4, q, qb, v);
  endtask

  localparam grp_t P40 = {18'h04444, 18'h33333, 18'h22222, 18'h11111};
  localparam grp_t P48 = {18'h3A5A5, 18'h12345, 18'h2F0F0, 18'h00C3C};
  localparam grp_t P4C = {18'h0ABCD, 18'h1DEAD, 18'h2BEEF, 18'h35555};
  localparam grp_t P44N = {18'h01010, 18'h02020, 18'h03030, 18'h04040};
  localparam grp_t P50 = {18'h10001, 18'h10002, 18'h10003, 18'h10004};
  localparam grp_t P54 = {18'h20001, 18'h20002, 18'h20003, 18'h20004};
  localparam grp_t P58 = {18'h30001, 18'h30002, 18'h30003, 18'h30004};
  localparam grp_t P5C = {18'h0F00F, 18'h0E00E, 18'h0D00D, 18'h0C00C};
  localparam grp_t PJ  = {18'h3FFFF, 18'h2AAAA, 18'h15555, 18'h3C3C3};

  task automatic t_reset();
    chk("R1 rd_valid", 32'(rd_valid), 0);
    chk("R1 rd_data", 32'(rd_data), 0);
    chk("R1 k_phase", 32'(k_phase), 0);
    @(negedge clk2x);
    chk("R1 k_phase toggles", 32'(k_phase), 1);
  endtask

  task automatic t_write_read();
    grp_t q; logic [15:0] v;
    wr1(8'h40, P40, 8'h00);
    rd1(8'h40, q, v);
    chk_grp("R3 write words", q, P40);
    chk("R5 valid before", 32'(v[5]), 0);
    chk("R5 valid window", 32'(v[9:6]), 32'hF);
    chk("R5 valid after", 32'(v[10]), 0);
    chk("R5 data zero idle", 32'(rd_data), 0);
  endtask

  task automatic t_wrap();
    grp_t q; logic [15:0] v;
    rd1(8'h43, q, v);
    chk_grp("R6 read aligned", q, P40);
    wr1(8'h4B, P48, 8'h00);
    rd1(8'h48, q, v);
    chk_grp("R6 write aligned", q, P48);
  endtask

  task automatic t_byte();
    grp_t q; logic [15:0] v;
    wr1(8'h44, {4{18'h3FFFF}}, 8'h00);
    wr1(8'h44, '0, 8'b11_10_01_00);
    rd1(8'h44, q, v);
    chk_grp("R4 byte lanes", q, {18'h3FFFF, 18'h3FE00, 18'h001FF, 18'h00000});
  endtask

  task automatic t_concurrent();
    grp_t qa, qb; logic [15:0] v;
    run2(1, 8'h40, 1, 8'h4C, P4C, 8'h00, 0, 0, 0, 0, '0, '1, 4, qa, qb, v);
    chk_grp("R7 read beside write", qa, P40);
    rd1(8'h4C, qa, v);
    chk_grp("R7 write beside read", qa, P4C);
  endtask

  task automatic t_hazard();
    grp_t qa, qb; logic [15:0] v;
    run2(1, 8'h44, 1, 8'h44, P44N, 8'h00, 0, 0, 0, 0, '0, '1, 4, qa, qb, v);
    chk_grp("R8 old data", qa, {18'h3FFFF, 18'h3FE00, 18'h001FF, 18'h00000});
    rd1(8'h44, qa, v);
    chk_grp("R8 new data later", qa, P44N);
  endtask

  task automatic t_read_spacing();
    grp_t qa, qb; logic [15:0] v;
    run2(1, 8'h40, 0, 0, '0, '1, 1, 8'h48, 0, 0, '0, '1, 4, qa, qb, v);
    chk_grp("R9 first read", qa, P40);
    chk_grp("R9 second read", qb, P48);
    chk("R9 seamless valid", 32'(v[13:6]), 32'hFF);
    chk("R9 valid end", 32'(v[14]), 0);
    run2(1, 8'h48, 0, 0, '0, '1, 1, 8'h40, 0, 0, '0, '1, 2, qa, qb, v);
    chk_grp("R9 accepted read", qa, P48);
    chk("R9 ignored read no valid", 32'(v[15:10]), 0);
  endtask

  task automatic t_write_spacing();
    grp_t qa, qb; logic [15:0] v;
    wr1(8'h50, P50, 8'h00);
    run2(0, 0, 1, 8'h54, P54, 8'h00, 0, 0, 1, 8'h50, PJ, 8'h00, 2, qa, qb, v);
    rd1(8'h50, qa, v);
    chk_grp("R10 ignored write", qa, P50);
    rd1(8'h54, qa, v);
    chk_grp("R10 accepted write", qa, P54);
    run2(0, 0, 1, 8'h58, P58, 8'h00, 0, 0, 1, 8'h5C, P5C, 8'h00, 4, qa, qb, v);
    rd1(8'h58, qa, v);
    chk_grp("R10 first of pair", qa, P58);
    rd1(8'h5C, qa, v);
    chk_grp("R10 second of pair", qa, P5C);
  endtask

  task automatic t_kbar();
    grp_t q; logic [15:0] v;
    int seen = 0;
    to_k_rise();
    for (int i = 0; i < 14; i++) begin
      if (i > 0) @(negedge clk2x);
      if (rd_valid) seen++;
      idle_inputs();
      rd_addr = 8'h40; wr_addr = 8'h40;
      if (i == 1) begin rd_sel_n = 1'b0; wr_sel_n = 1'b0; end
      if (i >= 3 && i <= 6) begin wr_data = 18'h2AAAA; wr_be_n = 2'b00; end
    end
    idle_inputs();
    chk("R2 no read on K#", 32'(seen), 0);
    rd1(8'h40, q, v);
    chk_grp("R2 no write on K#", q, P40);
  endtask

  task automatic t_idle();
    grp_t q; logic [15:0] v;
    int seen = 0;
    to_k_rise();
    for (int i = 0; i < 12; i++) begin
      if (i > 0) @(negedge clk2x);
      if (rd_valid) seen++;
      rd_sel_n = 1'b1; wr_sel_n = 1'b1; rd_addr = 8'h40; wr_addr = 8'h40;
      wr_data = 18'(i * 18'h01357); wr_be_n = 2'b00;
    end
    idle_inputs();
    chk("R11 idle no valid", 32'(seen), 0);
    rd1(8'h40, q, v);
    chk_grp("R11 idle memory kept", q, P40);
  endtask

  initial begin
    repeat (4) @(negedge clk2x);
    rst_n = 1'b1;
    t_reset();
    t_write_read();
    t_wrap();
    t_byte();
    t_concurrent();
    t_hazard();
    t_read_spacing();
    t_write_spacing();
    t_kbar();
    t_idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk2x);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule